// File: doc/BRIEF.md
# Ethernet MAC Event Counter Bank

This block keeps eight hardware event counters for an Ethernet MAC and exposes them through a small 32-bit register port. Each counter has a single-cycle event strobe from the MAC datapath: frames sent and received (good and bad), received CRC errors, receive-side MII errors, receive FIFO overflows, and cases where no receive descriptor was available. The good-frame counters are full width. The other six are 16-bit halves, packed two to a 32-bit word.

A control word holds one disable bit per counter. A set bit holds its counter at zero, so a single control write can freeze and clear the whole bank. Writing zero afterwards restarts every counter from zero. Counters saturate at their maximum value instead of wrapping. Software reads counters with a registered read that returns data one cycle after the request. Software is expected to fold the values into wider running totals.

Top module: `mac_evt_stats`

## Requirements
- R1: After a synchronous active-high reset, the control word is 0x00000000, every counter reads zero, and `rdata` is zero.
- R2: Strobe bit mapping is: bit0 TX good, bit1 TX bad, bit2 RX good, bit3 RX bad, bit4 CRC error, bit5 MII error, bit6 FIFO overflow, bit7 descriptor empty. While its disable bit is 0, a counter adds exactly one for each clock edge at which its strobe is high.
- R3: The control word is at byte offset 0x64. Its bits [7:0] are the disable bits, in the same bit order as the strobes. A read returns the current bits in [7:0] with zeros above. A write takes effect from the following clock edge.
- R4: While a disable bit is 1, its counter reads zero and ignores its strobe. The other counters are unaffected.
- R5: Writing 0xFFFFFFFF and then 0 to the control word clears every counter, and each then counts again from zero.
- R6: Offset 0x68 reads the full-width TX good count. Offset 0x6C reads the full-width RX good count.
- R7: Packed words are as follows. Offset 0x70 holds CRC errors in [31:16] and MII errors in [15:0]. Offset 0x74 holds FIFO overflows in [31:16] and descriptor empties in [15:0]. Offset 0x7C holds RX bad in [31:16] and TX bad in [15:0].
- R8: Full-width counters stop at 2^WIDE_W-1 and packed counters stop at 2^NARROW_W-1; neither wraps.
- R9: Reads of the reserved offset 0x78, and of any offset not listed above, return zero.
- R10: Writes to counter offsets are ignored and leave the counts unchanged.
- R11: If a strobe and a read of the same counter fall on one clock edge, the read returns the pre-increment value. The increment is kept.
- R12: `rdata` changes only one cycle after a clock edge with `rd_en` high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event strobes, one per counter (R2 order) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
A counter holding a wrong value shows up at the next read of its word, one cycle after the read request. This is true whether the fault is a lost increment, a missed clear, a stuck disable, or a wrap instead of a stop. A packed counter placed in the wrong half of its word reads as a mismatch in the other half, or in another word. Faults in the disable path show up at the first read after a control write: either a counter stays nonzero under its disable bit, or a neighbouring counter stops counting.

// File: rtl/evt_stats_pkg.sv
package evt_stats_pkg;

  localparam int NUM_EVT = 8;

  // event index == disable bit position
  localparam int EV_TX_GOOD  = 0;
  localparam int EV_TX_BAD   = 1;
  localparam int EV_RX_GOOD  = 2;
  localparam int EV_RX_BAD   = 3;
  localparam int EV_CRC      = 4;
  localparam int EV_MII      = 5;
  localparam int EV_OVFL     = 6;
  localparam int EV_NODESC   = 7;

  localparam int OFS_CTRL    = 'h64;
  localparam int OFS_TXGOOD  = 'h68;
  localparam int OFS_RXGOOD  = 'h6C;
  localparam int OFS_CRCMII  = 'h70;
  localparam int OFS_RXERR   = 'h74;
  localparam int OFS_RSVD    = 'h78;
  localparam int OFS_FAIL    = 'h7C;

  function automatic bit evt_is_wide(int idx);
    return (idx == EV_TX_GOOD) || (idx == EV_RX_GOOD);
  endfunction

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (inc && (q != TOP)) begin
      q <= q + 1'b1;
    end
  end
endmodule

// File: rtl/stats_read_mux.sv
module stats_read_mux
  import evt_stats_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_EVT-1:0]             ctrl,
  input  logic [NUM_EVT-1:0][31:0]       cnt_view,
  output logic [31:0]                    word
);
  always_comb begin
    word = '0;
    case (addr)
      ADDR_W'(OFS_CTRL):   word = 32'(ctrl);
      ADDR_W'(OFS_TXGOOD): word = cnt_view[EV_TX_GOOD];
      ADDR_W'(OFS_RXGOOD): word = cnt_view[EV_RX_GOOD];
      ADDR_W'(OFS_CRCMII): word = {cnt_view[EV_CRC][15:0],    cnt_view[EV_MII][15:0]};
      ADDR_W'(OFS_RXERR):  word = {cnt_view[EV_OVFL][15:0],   cnt_view[EV_NODESC][15:0]};
      ADDR_W'(OFS_FAIL):   word = {cnt_view[EV_RX_BAD][15:0], cnt_view[EV_TX_BAD][15:0]};
      default:             word = '0;
    endcase
  end
endmodule

// File: rtl/mac_evt_stats.sv
module mac_evt_stats
  import evt_stats_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        evt_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(OFS_CTRL);

  logic [NUM_EVT-1:0]       ctrl_q;
  logic [NUM_EVT-1:0][31:0] cnt_view;
  logic [31:0]              rd_word;

  // disable/clear register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && (addr == CTRL_ADDR)) begin
      ctrl_q <= wdata[NUM_EVT-1:0];
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cnt
    if (evt_is_wide(i)) begin : g_wide
      logic [WIDE_W-1:0] cq;
      sat_counter #(.W(WIDE_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (ctrl_q[i]),
        .inc (evt_i[i]),
        .q   (cq)
      );
      assign cnt_view[i] = 32'(cq);
    end else begin : g_narrow
      logic [NARROW_W-1:0] cq;
      sat_counter #(.W(NARROW_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (ctrl_q[i]),
        .inc (evt_i[i]),
        .q   (cq)
      );
      assign cnt_view[i] = 32'(cq);
    end
  end

  stats_read_mux #(.ADDR_W(ADDR_W)) u_mux (
    .addr     (addr),
    .ctrl     (ctrl_q),
    .cnt_view (cnt_view),
    .word     (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_word;
    end
  end
endmodule

// File: rtl/mac_evt_stats_chk.sv
module mac_evt_stats_chk
  import evt_stats_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [7:0]                 evt_i,
  input logic                       rd_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [31:0]                rdata,
  input logic [NUM_EVT-1:0]         ctrl_q,
  input logic [NUM_EVT-1:0][31:0]   cnt_view
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    localparam logic [31:0] MAXV = evt_is_wide(i) ?
      32'((64'd1 << WIDE_W) - 1) : 32'((64'd1 << NARROW_W) - 1);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(ctrl_q[i]) && $past(evt_i[i]) && ($past(cnt_view[i]) != MAXV))
        |-> (cnt_view[i] == $past(cnt_view[i]) + 32'd1));

    // R2
    count_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(ctrl_q[i]) && !$past(evt_i[i])) |-> (cnt_view[i] == $past(cnt_view[i])));

    // R4
    disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $past(ctrl_q[i]) |-> (cnt_view[i] == 32'd0));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(ctrl_q[i]) && ($past(cnt_view[i]) == MAXV)) |-> (cnt_view[i] == MAXV));
  end

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && ($past(addr) == ADDR_W'(OFS_RSVD))) |-> (rdata == 32'd0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));
endmodule

bind mac_evt_stats mac_evt_stats_chk #(
  .ADDR_W   (ADDR_W),
  .WIDE_W   (WIDE_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_i    (evt_i),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .ctrl_q   (ctrl_q),
  .cnt_view (cnt_view)
);

// File: tb/mac_evt_stats_bench.sv
module mac_evt_stats_bench;
  localparam logic [7:0] A_CTRL = 8'h64;
  localparam logic [7:0] A_TXG  = 8'h68;
  localparam logic [7:0] A_RXG  = 8'h6C;
  localparam logic [7:0] A_CM   = 8'h70;
  localparam logic [7:0] A_RE   = 8'h74;
  localparam logic [7:0] A_RSV  = 8'h78;
  localparam logic [7:0] A_FAIL = 8'h7C;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [7:0]  evt;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata, rdata_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  mac_evt_stats u_mac_evt_stats (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  mac_evt_stats #(.ADDR_W(8), .WIDE_W(12), .NARROW_W(8)) u_mac_evt_stats_small (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_s)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vs);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    v = rdata; vs = rdata_s;
  endtask

  task automatic pulse(input logic [7:0] mask, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt = mask;
    end
    @(negedge clk); evt = 8'h00;
  endtask

  task automatic clear_all;
    wr(A_CTRL, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v, vs;
    check("R1 rdata after reset", rdata, 32'h0);
    rd(A_CTRL, v, vs); check("R1 ctrl reset", v, 32'h0);
    rd(A_TXG, v, vs);  check("R1 txgood reset", v, 32'h0);
    rd(A_RXG, v, vs);  check("R1 rxgood reset", v, 32'h0);
    rd(A_CM, v, vs);   check("R1 crc/mii reset", v, 32'h0);
    rd(A_RE, v, vs);   check("R1 rxerr reset", v, 32'h0);
    rd(A_FAIL, v, vs); check("R1 fail reset", v, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v, vs;
    clear_all();
    pulse(8'h01, 5);
    pulse(8'h04, 3);
    pulse(8'h30, 7);
    pulse(8'h10, 2);
    pulse(8'hC0, 2);
    pulse(8'h40, 1);
    pulse(8'h0A, 4);
    pulse(8'h02, 2);
    rd(A_TXG, v, vs);  check("R6 R2 txgood", v, 32'd5);
    rd(A_RXG, v, vs);  check("R6 R2 rxgood", v, 32'd3);
    rd(A_CM, v, vs);   check("R7 R2 crc/mii", v, {16'd9, 16'd7});
    rd(A_RE, v, vs);   check("R7 R2 ovfl/nodesc", v, {16'd3, 16'd2});
    rd(A_FAIL, v, vs); check("R7 R2 rxbad/txbad", v, {16'd4, 16'd6});
  endtask

  task automatic t_ctrl;
    logic [31:0] v, vs;
    wr(A_CTRL, 32'h0000_00A5);
    rd(A_CTRL, v, vs); check("R3 ctrl readback", v, 32'h0000_00A5);
    wr(A_CTRL, 32'hFFFF_FF3C);
    rd(A_CTRL, v, vs); check("R3 ctrl upper bits zero", v, 32'h0000_003C);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_disable;
    logic [31:0] v, vs;
    clear_all();
    pulse(8'hFF, 4);
    wr(A_CTRL, 32'hFFFF_FFFF);
    pulse(8'hFF, 3);
    rd(A_TXG, v, vs);  check("R4 txgood disabled", v, 32'h0);
    rd(A_CM, v, vs);   check("R4 crc/mii disabled", v, 32'h0);
    rd(A_FAIL, v, vs); check("R4 fail disabled", v, 32'h0);
    wr(A_CTRL, 32'h0);
    pulse(8'h01, 2);
    rd(A_TXG, v, vs);  check("R5 txgood restarts from zero", v, 32'd2);
    rd(A_FAIL, v, vs); check("R5 fail restarts from zero", v, 32'h0);
    wr(A_CTRL, 32'h0000_0004);
    pulse(8'h05, 3);
    rd(A_TXG, v, vs);  check("R4 enabled neighbour counts", v, 32'd5);
    rd(A_RXG, v, vs);  check("R4 rxgood held at zero", v, 32'h0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v, vs;
    rd(A_RSV, v, vs);  check("R9 reserved offset", v, 32'h0);
    rd(8'h00, v, vs);  check("R9 offset 0x00", v, 32'h0);
    rd(8'h60, v, vs);  check("R9 offset 0x60", v, 32'h0);
    rd(8'h80, v, vs);  check("R9 offset 0x80", v, 32'h0);
    rd(8'h66, v, vs);  check("R9 unaligned 0x66", v, 32'h0);
  endtask

  task automatic t_wr_ignored;
    logic [31:0] v, vs;
    clear_all();
    pulse(8'h11, 5);
    wr(A_TXG, 32'h0000_1234);
    wr(A_CM, 32'hFFFF_FFFF);
    rd(A_TXG, v, vs);  check("R10 txgood write ignored", v, 32'd5);
    rd(A_CM, v, vs);   check("R10 crc/mii write ignored", v, {16'd5, 16'd0});
    rd(A_CTRL, v, vs); check("R10 ctrl untouched", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v, vs;
    // txgood is 5 from the previous task
    @(negedge clk); rd_en = 1'b1; addr = A_TXG; evt = 8'h01;
    @(negedge clk); rd_en = 1'b0; evt = 8'h00;
    check("R11 read returns pre-increment value", rdata, 32'd5);
    rd(A_TXG, v, vs); check("R11 increment kept", v, 32'd6);
  endtask

  task automatic t_hold;
    logic [31:0] v, vs;
    rd(A_FAIL, v, vs);
    @(negedge clk); addr = A_TXG; evt = 8'hFF;
    @(negedge clk); evt = 8'h00; addr = A_CTRL;
    @(negedge clk);
    check("R12 rdata holds without rd_en", rdata, v);
  endtask

  task automatic t_saturate;
    logic [31:0] v, vs;
    clear_all();
    pulse(8'hFF, 4100);
    rd(A_TXG, v, vs);  check("R2 main txgood long run", v, 32'd4100);
                       check("R8 wide counter stops at max", vs, 32'h0000_0FFF);
    rd(A_CM, v, vs);   check("R2 main crc/mii long run", v, {16'd4100, 16'd4100});
                       check("R8 packed counters stop at max", vs, 32'h00FF_00FF);
    rd(A_FAIL, v, vs); check("R8 packed fail word at max", vs, 32'h00FF_00FF);
    pulse(8'hFF, 3);
    rd(A_RXG, v, vs);  check("R8 no wrap after more events", vs, 32'h0000_0FFF);
  endtask

  initial begin
    rst = 1'b1; evt = 8'h00; wr_en = 1'b0; rd_en = 1'b0; addr = 8'h00; wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_ctrl();
    t_disable();
    t_unmapped();
    t_wr_ignored();
    t_collide();
    t_hold();
    t_saturate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule